// File: doc/BRIEF.md
# Audio link command slot decoder

This block sits on the codec side of a frame-based serial audio link. The shifter ahead of it has already pulled the tag, command address and command data slots out of each frame. Those slots arrive as parallel fields together with a one-cycle frame-complete strobe. The decoder uses a strapped two-bit codec identity and a primary/secondary mode input to decide whether the frame carries a register access meant for this codec. When it does, it issues a single-cycle read or write request with the register index and, for writes, the 16-bit value.

The tag validity rules differ between the two codec roles. A primary codec takes a command when the command-slot valid flag is set, and a write also needs the data-slot valid flag set in the same frame. A secondary codec takes a command only when both slot valid flags are clear. Writes are atomic: a write whose data is missing from its own frame is dropped, never merged with data from another frame. The decoder also keeps a sticky protocol error flag for commands that break the slot rules, and a clear input resets that flag.

Top module: `alc_cmd_decoder`

## Requirements
- R1: No request is issued unless frame_ok_tag is 1 and codec_id_tag equals codec_id.
- R2: cmd_addr bit 19 equal to 1 selects a read and 0 selects a write. In primary mode (primary=1), a read needs slot1_valid=1 and a write needs both slot1_valid=1 and slot2_valid=1.
- R3: In secondary mode (primary=0), a read or a write is accepted only when slot1_valid=0 and slot2_valid=0.
- R4: A register index with bit 0 set never produces a request.
- R5: An accepted frame raises exactly one of reg_rd or reg_wr for one cycle, in the cycle after the strobe. reg_index then carries cmd_addr bits 18:12, and for a write reg_wdata carries cmd_data. When no request is issued, reg_index and reg_wdata hold their values.
- R6: On a read, cmd_data is ignored and reg_wdata keeps its previous value.
- R7: A primary-mode write with slot1_valid=1 and slot2_valid=0 is a split write. It produces no request and sets protocol_error.
- R8: On a frame addressed to this codec that carries a command (primary: slot1_valid=1; secondary: both valid flags 0), protocol_error is set by two conditions. One is an odd index on an access that otherwise qualifies. The other is any nonzero bit in cmd_addr bits 11:0. Once set, the flag stays set.
- R9: err_clear clears protocol_error on the next edge. A new error in the same cycle wins over the clear.
- R10: When rst_n is low at a clock edge, all outputs go to 0. Without frame_done, no request is issued and protocol_error does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| codec_id | input | 2 | Strapped codec identity |
| primary | input | 1 | 1 = primary codec rules, 0 = secondary |
| frame_done | input | 1 | One-cycle strobe: slot fields below are complete |
| frame_ok_tag | input | 1 | Tag frame-valid flag |
| slot1_valid | input | 1 | Tag flag: command address slot valid |
| slot2_valid | input | 1 | Tag flag: command data slot valid |
| codec_id_tag | input | 2 | Codec identity carried in the tag |
| cmd_addr | input | 20 | Command address slot (bit 19 read flag, 18:12 index, 11:0 zero) |
| cmd_data | input | 16 | Write value field of the command data slot |
| err_clear | input | 1 | Clears protocol_error |
| reg_rd | output | 1 | One-cycle read request |
| reg_wr | output | 1 | One-cycle write request |
| reg_index | output | 7 | Register index of the request |
| reg_wdata | output | 16 | Write value of the last write request |
| protocol_error | output | 1 | Sticky command rule violation flag |

## Verification
The sweep covers every combination of the following: both codec roles, all four strapped identities and all four tag identities, every setting of the three tag flags, read and write, even and odd indices, and zero and nonzero low address bits. This separates the primary rules from the secondary ones and the identity match from the frame-valid gate. It also separates an odd-index rejection from a slot-flag rejection, and a split write from an ordinary ignored frame. The clear input is pulsed on only some frames. That shows whether the error flag is really sticky and whether a new error wins over a clear in the same cycle. Index and data values change from frame to frame, so a read that wrongly updates reg_wdata, or a request that latches stale fields, shows up.

// File: rtl/alc_pkg.sv
// Shared widths and the per-frame decision record of the command slot decoder.
package alc_pkg;
    parameter int SLOT_W = 20;
    parameter int IDX_W  = 7;
    parameter int DATA_W = 16;
    parameter int ID_W   = 2;
    localparam int LOW_W = SLOT_W - 1 - IDX_W;

    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
        logic odd_err;
        logic split_err;
        logic low_err;
    } frame_verdict_t;
endpackage

// File: rtl/alc_tag_qualifier.sv
// Combinational qualification of one frame's command.
// Assumes the slot fields are stable whenever frame_done is high.
// Applies the frame-valid and identity gate, the role-dependent slot flag
// rules, index alignment, and detects the three rule violations.
module alc_tag_qualifier
    import alc_pkg::*;
(
    input  logic              primary,
    input  logic [ID_W-1:0]   codec_id,
    input  logic              frame_ok_tag,
    input  logic              slot1_valid,
    input  logic              slot2_valid,
    input  logic [ID_W-1:0]   codec_id_tag,
    input  logic [SLOT_W-1:0] cmd_addr,
    output frame_verdict_t    verdict
);
    logic is_read;
    logic odd_idx;
    logic addressed;
    logic cmd_present;
    logic slots_ok;
    logic low_dirty;

    // Split the address slot into its fields.
    always_comb begin
        is_read   = cmd_addr[SLOT_W-1];
        odd_idx   = cmd_addr[LOW_W];
        low_dirty = |cmd_addr[LOW_W-1:0];
    end

    // Frame gate, command presence and the slot flag rules per codec role.
    always_comb begin
        addressed = frame_ok_tag && (codec_id_tag == codec_id);
        if (primary) begin
            cmd_present = addressed && slot1_valid;
            slots_ok    = cmd_present && (is_read || slot2_valid);
        end else begin
            cmd_present = addressed && !slot1_valid && !slot2_valid;
            slots_ok    = cmd_present;
        end
    end

    // Final verdict: requests need alignment; errors flag rule breaks.
    always_comb begin
        verdict.rd_ok     = slots_ok && is_read && !odd_idx;
        verdict.wr_ok     = slots_ok && !is_read && !odd_idx;
        verdict.odd_err   = slots_ok && odd_idx;
        verdict.split_err = cmd_present && primary && !is_read && !slot2_valid;
        verdict.low_err   = cmd_present && low_dirty;
    end
endmodule

// File: rtl/alc_request_reg.sv
// Registers the request pulses and their index/data fields.
// Assumes at most one of rd_ok/wr_ok is high. The index is loaded on any
// request and the data only on a write, so reads leave the data untouched.
module alc_request_reg
    import alc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic              rd_ok,
    input  logic              wr_ok,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [IDX_W-1:0]  reg_index,
    output logic [DATA_W-1:0] reg_wdata
);
    // One-cycle request pulses, launched only on a frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rd <= 1'b0;
            reg_wr <= 1'b0;
        end else begin
            reg_rd <= frame_done && rd_ok;
            reg_wr <= frame_done && wr_ok;
        end
    end

    // Capture the index for any request, the data only for a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_index <= '0;
            reg_wdata <= '0;
        end else if (frame_done) begin
            if (rd_ok || wr_ok) reg_index <= idx_in;
            if (wr_ok)          reg_wdata <= data_in;
        end
    end
endmodule

// File: rtl/alc_error_track.sv
// Sticky protocol error flag. A new violation seen on a frame strobe sets
// it and wins over a clear requested in the same cycle.
module alc_error_track (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done,
    input  logic violation,
    input  logic err_clear,
    output logic protocol_error
);
    // Set on a violation, else clear on request, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                       protocol_error <= 1'b0;
        else if (frame_done && violation) protocol_error <= 1'b1;
        else if (err_clear)               protocol_error <= 1'b0;
    end
endmodule

// File: rtl/alc_cmd_decoder.sv
// Top of the command slot decoder. Qualifies each completed frame, issues
// at most one register request per frame, and tracks rule violations.
// Assumes frame_done is a single-cycle strobe with stable slot fields.
module alc_cmd_decoder
    import alc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   codec_id,
    input  logic              primary,
    input  logic              frame_done,
    input  logic              frame_ok_tag,
    input  logic              slot1_valid,
    input  logic              slot2_valid,
    input  logic [ID_W-1:0]   codec_id_tag,
    input  logic [SLOT_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              err_clear,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [IDX_W-1:0]  reg_index,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              protocol_error
);
    frame_verdict_t verdict;
    logic           violation;

    alc_tag_qualifier qual_i (
        .primary      (primary),
        .codec_id     (codec_id),
        .frame_ok_tag (frame_ok_tag),
        .slot1_valid  (slot1_valid),
        .slot2_valid  (slot2_valid),
        .codec_id_tag (codec_id_tag),
        .cmd_addr     (cmd_addr),
        .verdict      (verdict)
    );

    // Any of the three rule breaks counts as a violation.
    always_comb violation = verdict.odd_err || verdict.split_err || verdict.low_err;

    alc_request_reg req_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .rd_ok      (verdict.rd_ok),
        .wr_ok      (verdict.wr_ok),
        .idx_in     (cmd_addr[SLOT_W-2 -: IDX_W]),
        .data_in    (cmd_data),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_index  (reg_index),
        .reg_wdata  (reg_wdata)
    );

    alc_error_track err_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_done     (frame_done),
        .violation      (violation),
        .err_clear      (err_clear),
        .protocol_error (protocol_error)
    );

    // R5: never a read and a write together.
    assert_one_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({reg_rd, reg_wr}) <= 1);

    // R10: a request only follows a frame strobe.
    assert_req_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rd) || $rose(reg_wr) |-> $past(frame_done));

    // R4: an issued request always carries an even index.
    assert_even_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd || reg_wr) |-> !reg_index[0]);

    // R1: a request needs the frame-valid flag and an identity match.
    assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !(frame_ok_tag && codec_id_tag == codec_id) |=> !reg_rd && !reg_wr);

    // R6: a read leaves the write data register untouched.
    assert_read_keeps_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && cmd_addr[SLOT_W-1] |=> $stable(reg_wdata));

    // R9: the error flag falls only after a clear request.
    assert_err_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(protocol_error) |-> $past(err_clear));

    // R8: the error flag rises only on a frame strobe.
    assert_err_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(protocol_error) |-> $past(frame_done));
endmodule

// File: tb/alc_cmd_decoder_tb_top.sv
module alc_cmd_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  codec_id;
    logic        primary;
    logic        frame_done;
    logic        frame_ok_tag;
    logic        slot1_valid;
    logic        slot2_valid;
    logic [1:0]  codec_id_tag;
    logic [19:0] cmd_addr;
    logic [15:0] cmd_data;
    logic        err_clear;
    logic        reg_rd;
    logic        reg_wr;
    logic [6:0]  reg_index;
    logic [15:0] reg_wdata;
    logic        protocol_error;

    int checks = 0;
    int errors = 0;

    // Model state.
    logic [6:0]  m_idx;
    logic [15:0] m_data;
    logic        m_err;

    always #2.5 clk = ~clk;

    alc_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .codec_id(codec_id), .primary(primary),
        .frame_done(frame_done), .frame_ok_tag(frame_ok_tag),
        .slot1_valid(slot1_valid), .slot2_valid(slot2_valid),
        .codec_id_tag(codec_id_tag), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .err_clear(err_clear), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_index(reg_index), .reg_wdata(reg_wdata),
        .protocol_error(protocol_error)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Drive one frame, check the cycle after the strobe, then the idle cycle.
    task automatic do_frame(input logic prim, input logic [1:0] cid, input logic fv,
                            input logic s1, input logic s2, input logic [1:0] tid,
                            input logic rd, input logic [6:0] idx, input logic [11:0] low,
                            input logic [15:0] data, input logic clr);
        logic present, ok, e_rd, e_wr, viol;
        present = fv && (tid == cid) && (prim ? s1 : (!s1 && !s2));
        ok      = present && (prim ? (rd || s2) : 1'b1);
        e_rd    = ok && rd && (idx % 2 == 0);
        e_wr    = ok && !rd && (idx % 2 == 0);
        viol    = (ok && idx % 2 == 1) || (present && prim && !rd && !s2) || (present && low != 0);
        @(negedge clk);
        primary = prim; codec_id = cid; frame_ok_tag = fv; slot1_valid = s1;
        slot2_valid = s2; codec_id_tag = tid; cmd_addr = {rd, idx, low};
        cmd_data = data; err_clear = clr; frame_done = 1'b1;
        @(negedge clk);
        if (e_rd || e_wr) m_idx = idx;
        if (e_wr) m_data = data;
        m_err = viol ? 1'b1 : (clr ? 1'b0 : m_err);
        check(prim ? "R2 read" : "R3 read", reg_rd, e_rd);
        check(prim ? "R2 write R7" : "R3 write", reg_wr, e_wr);
        check("R5 index", reg_index, m_idx);
        check(rd ? "R6 data held" : "R5 data", reg_wdata, m_data);
        check("R8 R9 error", protocol_error, m_err);
        frame_done = 1'b0; err_clear = 1'b0;
        @(negedge clk);
        check("R5 one-cycle pulse", {reg_rd, reg_wr}, 2'b00);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; frame_done = 1'b0; err_clear = 1'b0; primary = 1'b1;
        codec_id = 2'd0; frame_ok_tag = 1'b0; slot1_valid = 1'b0; slot2_valid = 1'b0;
        codec_id_tag = 2'd0; cmd_addr = '0; cmd_data = '0;
        m_idx = '0; m_data = '0; m_err = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 reset rd", reg_rd, 0);
        check("R10 reset wr", reg_wr, 0);
        check("R10 reset index", reg_index, 0);
        check("R10 reset data", reg_wdata, 0);
        check("R10 reset error", protocol_error, 0);
        rst_n = 1'b1;
        // Qualifying and erroneous fields but no strobe: nothing may happen.
        frame_ok_tag = 1'b1; slot1_valid = 1'b1; slot2_valid = 1'b1;
        cmd_addr = {1'b0, 7'h22, 12'h001}; cmd_data = 16'hBEEF;
        repeat (2) @(negedge clk);
        check("R10 no strobe rd", reg_rd, 0);
        check("R10 no strobe wr", reg_wr, 0);
        check("R10 no strobe error", protocol_error, 0);
        // Full sweep over a small configuration.
        for (int n = 0; n < 2048; n++) begin
            logic [6:0] idx;
            idx = 7'(((n * 37) & 7'h7E) | ((n >> 4) & 1));
            do_frame(n[0], n[2:1], n[3], n[5], n[6], n[8:7], n[9], idx,
                     n[10] ? 12'(n * 3 + 1) : 12'h000,
                     16'(n * 16'h9E37 ^ 16'h5A5A), (n % 3) == 0);
        end
        // R9: a new error in the same cycle as a clear wins.
        do_frame(1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 7'h10, 12'h0, 16'h1234, 1'b1);
        check("R9 set wins", protocol_error, 1);
        do_frame(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 7'h10, 12'h0, 16'h0, 1'b1);
        check("R9 cleared", protocol_error, 0);
        finish_run();
    end
endmodule